// File: doc/BRIEF.md
# Double-Buffered OUT Endpoint Receive Controller

This block keeps the receive-side bookkeeping for one OUT endpoint of a full-speed device. The serial engine reports each finished data packet with its length, its data toggle and whether it arrived damaged. The block decides whether the packet is kept, answers with a handshake code in bulk and interrupt mode, and records it in a queue of one or two packet slots. The packet bytes themselves live in a memory outside this block. Only lengths and error marks are held here.

The CPU sees the packet at the head of the queue through a ready flag and a byte count, and unloads it one byte at a time with a read strobe. A packet leaves the queue on a manual release, on a flush, or automatically once a full maximum-size packet has been read out. Isochronous mode drops handshakes, stores damaged packets with an error mark, and records packets lost for lack of space. A stall request answers every bulk packet with STALL and sets a sticky flag.

Top module: `oep_ctrl`

## Requirements
- R1: After reset, pkt_rdy, buf_full, iso_ovr, iso_data_err, stall_sent, tog_exp, irq and hs_valid are all 0 and pkt_cnt is 0.
- R2: In bulk mode (cfg_iso=0), a packet whose rx_tog equals tog_exp is stored when the queue has room. On the next cycle hs_valid=1 with hs_code=1 (ACK), pkt_rdy=1, and tog_exp is inverted.
- R3: The queue holds one packet when cfg_dbl=0 and two when cfg_dbl=1, and buf_full is 1 exactly when the queue holds that many. A bulk packet arriving while buf_full=1 gets hs_code=2 (NAK) and is not stored.
- R4: In bulk mode, a packet whose rx_tog differs from tog_exp gets ACK. It is discarded, and tog_exp is left unchanged.
- R5: In isochronous mode (cfg_iso=1), no handshake is produced (hs_valid stays 0), and rx_tog plays no part in whether a packet is stored. A packet arriving while buf_full=1 is dropped and sets iso_ovr, which stays set until cmd_clr_ovr.
- R6: In isochronous mode, a packet stored with rx_err=1 shows iso_data_err=1 while it is at the head. iso_data_err falls to 0 when that packet leaves the queue.
- R7: With cfg_auto_clr=1, if the head packet is exactly cfg_max_units*8 bytes long, the read strobe that unloads its last byte also removes it from the queue. A shorter packet stays until it is released by hand.
- R8: Each cmd_flush or cmd_clr_rdy removes only the head packet. With two packets held, the second becomes the head and its length appears on pkt_cnt. Packets leave in arrival order.
- R9: In bulk mode with cfg_send_stall=1, every packet gets hs_code=3 (STALL) and is not stored. stall_sent is set and stays set until cmd_clr_stall.
- R10: cmd_clr_tog forces tog_exp to 0 (DATA0) on the next cycle.
- R11: irq is 1 whenever pkt_rdy or stall_sent is 1.
- R12: pkt_cnt shows the head packet's 11-bit length while pkt_rdy=1 and reads 0 otherwise.
- R13: When a packet arrives in the same cycle as a release, room is judged on the occupancy before the release. A full single buffer therefore NAKs it. A double buffer holding one packet stores it, and the new packet becomes the head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_iso | input | 1 | 1 = isochronous, 0 = bulk/interrupt |
| cfg_dbl | input | 1 | 1 = two packet slots |
| cfg_auto_clr | input | 1 | Release a maximum-size packet when its last byte is read |
| cfg_max_units | input | 8 | Maximum packet size in 8-byte units |
| cfg_send_stall | input | 1 | Answer bulk packets with STALL |
| cmd_clr_rdy | input | 1 | Release the head packet |
| cmd_flush | input | 1 | Drop the head packet |
| cmd_clr_tog | input | 1 | Reset the expected toggle to DATA0 |
| cmd_clr_stall | input | 1 | Clear stall_sent |
| cmd_clr_ovr | input | 1 | Clear iso_ovr |
| rx_valid | input | 1 | One-cycle strobe: a packet has finished |
| rx_len | input | 11 | Packet length in bytes |
| rx_tog | input | 1 | Data toggle of the packet (0 = DATA0) |
| rx_err | input | 1 | CRC or bit-stuff error on the packet |
| rd_en | input | 1 | CPU unloads one byte of the head packet |
| hs_valid | output | 1 | Handshake code valid (one cycle after rx_valid) |
| hs_code | output | 2 | 1 ACK, 2 NAK, 3 STALL |
| pkt_rdy | output | 1 | A packet waits at the head |
| pkt_cnt | output | 11 | Head packet length |
| buf_full | output | 1 | No room for another packet |
| iso_ovr | output | 1 | Isochronous packet was lost |
| iso_data_err | output | 1 | Head packet arrived damaged |
| stall_sent | output | 1 | A STALL was returned |
| tog_exp | output | 1 | Expected data toggle |
| irq | output | 1 | Interrupt request |

## Verification
The two functions that collide are a packet's arrival and the removal of the head packet. Both change the occupancy in the same edge, and the room check must use the occupancy before the removal. The bench provokes this by raising rx_valid and cmd_clr_rdy in one cycle, once against a full single buffer and once against a half-full double buffer. It then judges the handshake code, pkt_rdy, buf_full and the length now at the head against R13.

// File: rtl/oep_pkg.sv
package oep_pkg;
  typedef enum logic [1:0] {
    HS_NONE  = 2'd0,
    HS_ACK   = 2'd1,
    HS_NAK   = 2'd2,
    HS_STALL = 2'd3
  } hs_e;

  // Maximum packet size in bytes from a count of 8-byte units
  function automatic logic [10:0] unit_bytes(input logic [7:0] units);
    return {units, 3'b000};
  endfunction

  // Handshake choice for one arriving packet
  function automatic hs_e pick_hs(input logic iso, input logic stall, input logic full);
    if (iso)        return HS_NONE;
    else if (stall) return HS_STALL;
    else if (full)  return HS_NAK;
    else            return HS_ACK;
  endfunction
endpackage

// File: rtl/oep_queue.sv
module oep_queue #(
  parameter int SLOTS = 2,
  parameter int LW    = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          two_slots,
  input  logic          push,
  input  logic [LW-1:0] push_len,
  input  logic          push_err,
  input  logic          pop,
  output logic          full,
  output logic          ready,
  output logic [LW-1:0] head_len,
  output logic          head_err
);
  localparam int PW = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int OW = $clog2(SLOTS + 1);

  logic [LW-1:0] len_q [SLOTS];
  logic          err_q [SLOTS];
  logic [PW-1:0] head_q, tail_q;
  logic [OW-1:0] occ_q;
  logic [OW-1:0] cap;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] i);
    return (i == PW'(SLOTS - 1)) ? '0 : i + 1'b1;
  endfunction

  assign cap      = two_slots ? OW'(SLOTS) : OW'(1);
  assign full     = (occ_q >= cap);
  assign ready    = (occ_q != '0);
  assign head_len = len_q[head_q];
  assign head_err = err_q[head_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SLOTS; s++) begin
        len_q[s] <= '0;
        err_q[s] <= 1'b0;
      end
    end else if (push) begin
      len_q[tail_q] <= push_len;
      err_q[tail_q] <= push_err;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      occ_q  <= '0;
    end else begin
      if (pop)  head_q <= nxt(head_q);
      if (push) tail_q <= nxt(tail_q);
      occ_q <= occ_q + OW'(push) - OW'(pop);
    end
  end

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full) else $error("push into full queue");

  // R3
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q <= OW'(SLOTS)) else $error("occupancy beyond slot count");

  // R8
  pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> ready) else $error("release of empty queue");
endmodule

// File: rtl/oep_admit.sv
module oep_admit
  import oep_pkg::*;
(
  input  logic       rx_valid,
  input  logic       iso,
  input  logic       send_stall,
  input  logic       full,
  input  logic       tog_match,
  output hs_e        code,
  output logic       store,
  output logic       flip,
  output logic       ovr_evt,
  output logic       stall_evt
);
  assign code      = pick_hs(iso, send_stall, full);
  assign store     = rx_valid & (iso ? !full : (code == HS_ACK) & tog_match);
  assign flip      = store & !iso;
  assign ovr_evt   = rx_valid & iso & full;
  assign stall_evt = rx_valid & (code == HS_STALL);
endmodule

// File: rtl/oep_ctrl.sv
module oep_ctrl
  import oep_pkg::*;
#(
  parameter int SLOTS = 2,
  parameter int LW    = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_iso,
  input  logic          cfg_dbl,
  input  logic          cfg_auto_clr,
  input  logic [7:0]    cfg_max_units,
  input  logic          cfg_send_stall,
  input  logic          cmd_clr_rdy,
  input  logic          cmd_flush,
  input  logic          cmd_clr_tog,
  input  logic          cmd_clr_stall,
  input  logic          cmd_clr_ovr,
  input  logic          rx_valid,
  input  logic [LW-1:0] rx_len,
  input  logic          rx_tog,
  input  logic          rx_err,
  input  logic          rd_en,
  output logic          hs_valid,
  output logic [1:0]    hs_code,
  output logic          pkt_rdy,
  output logic [LW-1:0] pkt_cnt,
  output logic          buf_full,
  output logic          iso_ovr,
  output logic          iso_data_err,
  output logic          stall_sent,
  output logic          tog_exp,
  output logic          irq
);
  hs_e           code;
  logic          store, flip, ovr_evt, stall_evt;
  logic          full, ready, head_err, auto_pop, pop;
  logic [LW-1:0] head_len, rd_cnt_q, max_len;
  logic          tog_q, ovr_q, stall_q, hs_valid_q;
  hs_e           hs_code_q;

  oep_admit u_admit (
    .rx_valid   (rx_valid),
    .iso        (cfg_iso),
    .send_stall (cfg_send_stall),
    .full       (full),
    .tog_match  (rx_tog == tog_q),
    .code       (code),
    .store      (store),
    .flip       (flip),
    .ovr_evt    (ovr_evt),
    .stall_evt  (stall_evt)
  );

  oep_queue #(.SLOTS(SLOTS), .LW(LW)) u_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .two_slots (cfg_dbl),
    .push      (store),
    .push_len  (rx_len),
    .push_err  (rx_err & cfg_iso),
    .pop       (pop),
    .full      (full),
    .ready     (ready),
    .head_len  (head_len),
    .head_err  (head_err)
  );

  assign max_len  = LW'(unit_bytes(cfg_max_units));
  assign auto_pop = cfg_auto_clr & rd_en & ready & (head_len == max_len)
                  & ((rd_cnt_q + 1'b1) == head_len);
  assign pop      = ready & (cmd_clr_rdy | cmd_flush | auto_pop);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_cnt_q   <= '0;
      tog_q      <= 1'b0;
      ovr_q      <= 1'b0;
      stall_q    <= 1'b0;
      hs_valid_q <= 1'b0;
      hs_code_q  <= HS_NONE;
    end else begin
      if (pop)                rd_cnt_q <= '0;
      else if (rd_en & ready) rd_cnt_q <= rd_cnt_q + 1'b1;
      if (cmd_clr_tog) tog_q <= 1'b0;
      else if (flip)   tog_q <= ~tog_q;
      if (ovr_evt)          ovr_q <= 1'b1;
      else if (cmd_clr_ovr) ovr_q <= 1'b0;
      if (stall_evt)          stall_q <= 1'b1;
      else if (cmd_clr_stall) stall_q <= 1'b0;
      hs_valid_q <= rx_valid & !cfg_iso;
      hs_code_q  <= code;
    end
  end

  assign hs_valid     = hs_valid_q;
  assign hs_code      = hs_valid_q ? hs_code_q : HS_NONE;
  assign pkt_rdy      = ready;
  assign pkt_cnt      = ready ? head_len : '0;
  assign buf_full     = full;
  assign iso_ovr      = ovr_q;
  assign iso_data_err = ready & head_err;
  assign stall_sent   = stall_q;
  assign tog_exp      = tog_q;
  assign irq          = ready | stall_q;

  // R2
  stored_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    store |=> pkt_rdy) else $error("stored packet not ready");

  // R9
  stall_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_valid && hs_code == 2'd3) |-> stall_sent) else $error("STALL without flag");

  // R5
  iso_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && cfg_iso) |=> !hs_valid) else $error("handshake in iso mode");

  // R10
  tog_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_clr_tog |=> !tog_exp) else $error("toggle not cleared");

  // R4
  tog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !cfg_iso && !store && !cmd_clr_tog) |=> $stable(tog_exp))
    else $error("toggle moved on unstored packet");
endmodule

// File: tb/oep_ctrl_tb.sv
`timescale 1ns/1ps
module oep_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_iso = 0, cfg_dbl = 0, cfg_auto_clr = 0, cfg_send_stall = 0;
  logic [7:0]  cfg_max_units = 8'd2;
  logic [4:0]  cmd = '0; // {clr_rdy, flush, clr_tog, clr_stall, clr_ovr}
  logic        rx_valid = 0, rx_tog = 0, rx_err = 0, rd_en = 0;
  logic [10:0] rx_len = '0;
  logic        hs_valid, pkt_rdy, buf_full, iso_ovr, iso_data_err, stall_sent, tog_exp, irq;
  logic [1:0]  hs_code;
  logic [10:0] pkt_cnt;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  oep_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_iso(cfg_iso), .cfg_dbl(cfg_dbl),
    .cfg_auto_clr(cfg_auto_clr), .cfg_max_units(cfg_max_units),
    .cfg_send_stall(cfg_send_stall), .cmd_clr_rdy(cmd[4]), .cmd_flush(cmd[3]),
    .cmd_clr_tog(cmd[2]), .cmd_clr_stall(cmd[1]), .cmd_clr_ovr(cmd[0]),
    .rx_valid(rx_valid), .rx_len(rx_len), .rx_tog(rx_tog), .rx_err(rx_err),
    .rd_en(rd_en), .hs_valid(hs_valid), .hs_code(hs_code), .pkt_rdy(pkt_rdy),
    .pkt_cnt(pkt_cnt), .buf_full(buf_full), .iso_ovr(iso_ovr),
    .iso_data_err(iso_data_err), .stall_sent(stall_sent), .tog_exp(tog_exp), .irq(irq)
  );

  localparam logic [1:0] ACK = 2'd1, NAK = 2'd2, STALL = 2'd3;

  typedef struct packed {
    logic        is_pop;
    logic [10:0] len;
    logic        tog;
    logic [1:0]  hs;
    logic        rdy;
    logic [10:0] cnt;
    logic        full;
  } vec_t;

  // Bulk, two slots: R2 R3 R4 R8 rows
  localparam vec_t VEC [8] = '{
    '{1'b0, 11'd10, 1'b0, 2'd1, 1'b1, 11'd10, 1'b0},
    '{1'b0, 11'd20, 1'b1, 2'd1, 1'b1, 11'd10, 1'b1},
    '{1'b0, 11'd5,  1'b0, 2'd2, 1'b1, 11'd10, 1'b1},
    '{1'b1, 11'd0,  1'b0, 2'd0, 1'b1, 11'd20, 1'b0},
    '{1'b0, 11'd7,  1'b1, 2'd1, 1'b1, 11'd20, 1'b0},
    '{1'b0, 11'd7,  1'b0, 2'd1, 1'b1, 11'd20, 1'b1},
    '{1'b1, 11'd0,  1'b0, 2'd0, 1'b1, 11'd7,  1'b0},
    '{1'b1, 11'd0,  1'b0, 2'd0, 1'b0, 11'd0,  1'b0}
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive for one cycle, then sample at the following falling edge
  task automatic pkt(input logic [10:0] len, input logic tog, input logic err,
                     input logic [4:0] c);
    @(negedge clk);
    rx_valid = 1; rx_len = len; rx_tog = tog; rx_err = err; cmd = c;
    @(negedge clk);
    rx_valid = 0; rx_err = 0; cmd = '0;
  endtask

  task automatic do_cmd(input logic [4:0] c);
    @(negedge clk);
    cmd = c;
    @(negedge clk);
    cmd = '0;
  endtask

  task automatic reads(input int n);
    @(negedge clk);
    rd_en = 1;
    repeat (n) @(negedge clk);
    rd_en = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 rdy", pkt_rdy, 0);   chk("R1 full", buf_full, 0);
    chk("R1 ovr", iso_ovr, 0);   chk("R1 stall", stall_sent, 0);
    chk("R1 tog", tog_exp, 0);   chk("R1 irq", irq, 0);
    chk("R1 hs", hs_valid, 0);   chk("R1 cnt", pkt_cnt, 0);
    rst_n = 1;
    @(negedge clk);

    // vector table: bulk, double buffer
    cfg_dbl = 1;
    for (int i = 0; i < 8; i++) begin
      if (VEC[i].is_pop) begin
        do_cmd(5'b10000);
        chk("R8 nohs", hs_valid, 0);
      end else begin
        pkt(VEC[i].len, VEC[i].tog, 1'b0, 5'b0);
        chk("R2/R3/R4 hs_valid", hs_valid, 1);
        chk("R2/R3/R4 hs_code", hs_code, VEC[i].hs);
      end
      chk("R13 rdy", pkt_rdy, VEC[i].rdy);
      chk("R12 cnt", pkt_cnt, VEC[i].cnt);
      chk("R3 full", buf_full, VEC[i].full);
    end

    // R10 toggle reset after an accepted packet
    do_cmd(5'b00100);
    pkt(11'd3, 1'b0, 1'b0, 5'b0);
    chk("R2 tog flip", tog_exp, 1);
    do_cmd(5'b00100);
    chk("R10 tog cleared", tog_exp, 0);
    do_cmd(5'b10000);

    // R8 two flushes
    pkt(11'd11, 1'b0, 1'b0, 5'b0);
    pkt(11'd12, 1'b1, 1'b0, 5'b0);
    do_cmd(5'b01000);
    chk("R8 second head", pkt_cnt, 12);
    chk("R8 still ready", pkt_rdy, 1);
    do_cmd(5'b01000);
    chk("R8 empty", pkt_rdy, 0);

    // R13 simultaneous arrival and release, double buffer one held
    do_cmd(5'b00100);
    pkt(11'd3, 1'b0, 1'b0, 5'b0);
    pkt(11'd9, 1'b1, 1'b0, 5'b10000);
    chk("R13 dbl hs", hs_code, ACK);
    chk("R13 dbl cnt", pkt_cnt, 9);
    chk("R13 dbl full", buf_full, 0);
    do_cmd(5'b10000);

    // R13 full single buffer
    cfg_dbl = 0;
    do_cmd(5'b00100);
    pkt(11'd4, 1'b0, 1'b0, 5'b0);
    chk("R3 single full", buf_full, 1);
    pkt(11'd6, 1'b1, 1'b0, 5'b10000);
    chk("R13 single hs", hs_code, NAK);
    chk("R13 single rdy", pkt_rdy, 0);
    chk("R11 irq low", irq, 0);

    // R7 auto release
    cfg_auto_clr = 1; cfg_max_units = 8'd2;
    do_cmd(5'b00100);
    pkt(11'd16, 1'b0, 1'b0, 5'b0);
    chk("R11 irq rdy", irq, 1);
    reads(15);
    chk("R7 after 15", pkt_rdy, 1);
    reads(1);
    chk("R7 after 16", pkt_rdy, 0);
    pkt(11'd8, 1'b1, 1'b0, 5'b0);
    reads(8);
    chk("R7 short stays", pkt_rdy, 1);
    do_cmd(5'b10000);
    chk("R7 manual", pkt_rdy, 0);
    cfg_auto_clr = 0;

    // R9 stall
    cfg_send_stall = 1;
    pkt(11'd5, 1'b0, 1'b0, 5'b0);
    chk("R9 code", hs_code, STALL);
    chk("R9 flag", stall_sent, 1);
    chk("R9 not stored", pkt_rdy, 0);
    chk("R11 irq stall", irq, 1);
    cfg_send_stall = 0;
    do_cmd(5'b00010);
    chk("R9 cleared", stall_sent, 0);

    // R5 R6 isochronous
    cfg_iso = 1;
    pkt(11'd4, 1'b1, 1'b1, 5'b0);
    chk("R5 no hs", hs_valid, 0);
    chk("R5 stored", pkt_rdy, 1);
    chk("R6 derr", iso_data_err, 1);
    pkt(11'd7, 1'b0, 1'b0, 5'b0);
    chk("R5 ovr", iso_ovr, 1);
    chk("R5 head kept", pkt_cnt, 4);
    do_cmd(5'b10000);
    chk("R6 derr gone", iso_data_err, 0);
    chk("R5 ovr sticky", iso_ovr, 1);
    do_cmd(5'b00001);
    chk("R5 ovr cleared", iso_ovr, 0);
    pkt(11'd2, 1'b0, 1'b0, 5'b0);
    chk("R6 clean", iso_data_err, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule